// File: doc/BRIEF.md
# PCI Bus Phase Qualifier

This block watches a conventional PCI bus without driving it. On every bus clock it samples the active-low control lines and reports, one clock later, what kind of clock the bus has just gone through. A trace capture unit downstream can then store or trigger on these flags. The flags mark an address phase, a completed data transfer, the last transfer, an idle bus, and the three terminations without data (retry, target abort, master abort). A clock on which neither side is ready is tagged with the party that caused the wait.

The command on the byte-enable lines is captured at the address phase and held until the next address phase. The grant line is registered as a separate qualifier. The monitor follows one transaction at a time. A transaction opens when FRAME# goes active while no transaction is in progress. It closes on the first clock on which FRAME# and IRDY# are both inactive.

The block has no data stream and no handshake. Every pin is a plain level, and every output is a registered flag that is valid for exactly one clock per event.

Top module: `pci_phase_tagger`

## Requirements
- R1: `addr_vld` is 1 for a clock whose sample has FRAME# active while no transaction was open (the prior sample idle, or after reset). FRAME# staying active inside an open transaction never raises it again.
- R2: `data_vld` is 1 for each clock inside an open transaction whose sample has both IRDY# and TRDY# active.
- R3: `last_xfer` is 1 exactly when a transfer (R2) happens with FRAME# inactive.
- R4: `retry_flag` pulses for one clock when STOP# and DEVSEL# are active and TRDY# is inactive before any transfer has completed in the transaction. Later STOP# clocks of the same transaction raise no further termination flag.
- R5: `tgt_abort` pulses for one clock when STOP# is active, DEVSEL# is inactive, and DEVSEL# was seen earlier in the transaction.
- R6: `mst_abort` pulses when FRAME# is inactive, IRDY# is active, and DEVSEL# has not been seen, on a clock more than `WIN_CLKS` (default 4) clocks after the address phase. At exactly `WIN_CLKS` clocks the clock is still a no-DEVSEL wait.
- R7: A transaction clock with no transfer, no STOP# and no abort raises exactly one wait flag. `wait_nodev` is raised when DEVSEL# is inactive. Otherwise `wait_tgt` is raised when IRDY# is active. Otherwise `wait_mst` is raised, and this covers a clock on which both IRDY# and TRDY# are inactive.
- R8: `bus_idle` is 1 for a clock whose sample has FRAME# and IRDY# both inactive.
- R9: `cmd_held` takes the 4-bit C/BE# value, bits unchanged, in the same clock that `addr_vld` is raised. It holds that value through the data phases whatever C/BE# carries.
- R10: `gnt_held` is 1 one clock after GNT# was sampled active, independent of bus state.
- R11: Every output reflects the sample of the previous clock edge. A synchronous reset clears all outputs, including `cmd_held`, and closes any open transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| stop_n | input | 1 | STOP#, active low |
| gnt_n | input | 1 | GNT#, active low |
| cbe_n | input | 4 | C/BE# lines |
| addr_vld | output | 1 | Address phase |
| data_vld | output | 1 | Data transfer |
| last_xfer | output | 1 | Final transfer of transaction |
| retry_flag | output | 1 | Retry termination |
| tgt_abort | output | 1 | Target abort |
| mst_abort | output | 1 | Master abort |
| wait_tgt | output | 1 | Wait caused by target |
| wait_mst | output | 1 | Wait caused by master |
| wait_nodev | output | 1 | Wait with no DEVSEL# yet |
| bus_idle | output | 1 | Idle bus |
| gnt_held | output | 1 | Registered grant |
| cmd_held | output | 4 | Latched command |

## Verification
The bench builds the block with the default `WIN_CLKS` of 4. With that window, the master-abort edge can be reached within a few clocks. The bench releases FRAME# on the fourth clock after the address phase, which must still read as a no-DEVSEL wait, and a fifth clock that must read as a master abort. A subtractive-speed DEVSEL# on the fourth clock must produce a plain final transfer. A reset in the middle of a transaction shows that the open transaction and the latched command are both discarded.

// File: rtl/pci_mon_pkg.sv
package pci_mon_pkg;

  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic devsel;
    logic stop;
  } bus_ctl_t;

  typedef struct packed {
    logic addr;
    logic data;
    logic last;
    logic retry;
    logic tabort;
    logic mabort;
    logic wait_tgt;
    logic wait_mst;
    logic wait_nodev;
    logic idle;
  } phase_flags_t;

endpackage

// File: rtl/pci_txn_tracker.sv
module pci_txn_tracker #(
  parameter int WIN_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic frame,
  input  logic irdy,
  input  logic trdy,
  input  logic devsel,
  input  logic term_evt,
  output logic addr_c,
  output logic dphase,
  output logic devsel_seen,
  output logic xfer_done,
  output logic term_seen,
  output logic win_over
);
  localparam int CNT_W = $clog2(WIN_CLKS + 2);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN_CLKS);

  logic             busy_q;
  logic             devsel_q;
  logic             xfer_q;
  logic             term_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle_now;

  assign idle_now    = !frame && !irdy;
  assign addr_c      = frame && !busy_q;
  assign dphase      = busy_q && !idle_now;
  assign devsel_seen = devsel_q;
  assign xfer_done   = xfer_q;
  assign term_seen   = term_q;
  assign win_over    = cnt_q > WIN_C;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      devsel_q <= 1'b0;
      xfer_q   <= 1'b0;
      term_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (addr_c) begin
      busy_q   <= 1'b1;
      devsel_q <= 1'b0;
      xfer_q   <= 1'b0;
      term_q   <= 1'b0;
      cnt_q    <= CNT_W'(1);
    end else if (dphase) begin
      devsel_q <= devsel_q | devsel;
      xfer_q   <= xfer_q | (irdy & trdy);
      term_q   <= term_q | term_evt;
      if (cnt_q <= WIN_C) cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_term_detect.sv
module pci_term_detect
  import pci_mon_pkg::*;
(
  input  bus_ctl_t ctl,
  input  logic     dphase,
  input  logic     devsel_seen,
  input  logic     xfer_done,
  input  logic     term_seen,
  input  logic     win_over,
  output logic     data_c,
  output logic     last_c,
  output logic     retry_c,
  output logic     tabort_c,
  output logic     mabort_c,
  output logic     term_evt
);
  logic stop_fresh;

  assign stop_fresh = dphase && ctl.stop && !term_seen;
  assign data_c     = dphase && ctl.irdy && ctl.trdy;
  assign last_c     = data_c && !ctl.frame;
  assign retry_c    = stop_fresh && ctl.devsel && !ctl.trdy && !xfer_done;
  assign tabort_c   = stop_fresh && !ctl.devsel && devsel_seen;
  assign mabort_c   = dphase && !term_seen && !devsel_seen && !ctl.devsel
                      && win_over && !ctl.frame && ctl.irdy;
  assign term_evt   = retry_c || tabort_c || mabort_c;

endmodule

// File: rtl/pci_wait_sort.sv
module pci_wait_sort (
  input  logic dphase,
  input  logic irdy,
  input  logic trdy,
  input  logic devsel,
  input  logic stop,
  input  logic term_seen,
  input  logic mabort_c,
  output logic wait_tgt,
  output logic wait_mst,
  output logic wait_nodev
);
  logic wait_any;

  assign wait_any = dphase && !(irdy && trdy) && !stop && !mabort_c && !term_seen;

  always_comb begin
    wait_tgt   = 1'b0;
    wait_mst   = 1'b0;
    wait_nodev = 1'b0;
    if (wait_any) begin
      if (!devsel)   wait_nodev = 1'b1;
      else if (irdy) wait_tgt   = 1'b1;
      else           wait_mst   = 1'b1;
    end
  end

endmodule

// File: rtl/pci_phase_tagger.sv
module pci_phase_tagger
  import pci_mon_pkg::*;
#(
  parameter int WIN_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       devsel_n,
  input  logic       stop_n,
  input  logic       gnt_n,
  input  logic [3:0] cbe_n,
  output logic       addr_vld,
  output logic       data_vld,
  output logic       last_xfer,
  output logic       retry_flag,
  output logic       tgt_abort,
  output logic       mst_abort,
  output logic       wait_tgt,
  output logic       wait_mst,
  output logic       wait_nodev,
  output logic       bus_idle,
  output logic       gnt_held,
  output logic [3:0] cmd_held
);
  localparam int CHK_W = $clog2(WIN_CLKS + 2);
  localparam logic [CHK_W-1:0] CHK_WIN = CHK_W'(WIN_CLKS);

  bus_ctl_t     ctl;
  phase_flags_t nxt, flags_q;
  logic         addr_c, dphase, devsel_seen, xfer_done, term_seen, win_over;
  logic         term_evt;
  logic [3:0]   cmd_q;
  logic         gnt_q;

  assign ctl.frame  = !frame_n;
  assign ctl.irdy   = !irdy_n;
  assign ctl.trdy   = !trdy_n;
  assign ctl.devsel = !devsel_n;
  assign ctl.stop   = !stop_n;

  pci_txn_tracker #(.WIN_CLKS(WIN_CLKS)) u_track (
    .clk(clk), .rst(rst),
    .frame(ctl.frame), .irdy(ctl.irdy), .trdy(ctl.trdy), .devsel(ctl.devsel),
    .term_evt(term_evt),
    .addr_c(addr_c), .dphase(dphase), .devsel_seen(devsel_seen),
    .xfer_done(xfer_done), .term_seen(term_seen), .win_over(win_over)
  );

  pci_term_detect u_term (
    .ctl(ctl), .dphase(dphase), .devsel_seen(devsel_seen),
    .xfer_done(xfer_done), .term_seen(term_seen), .win_over(win_over),
    .data_c(nxt.data), .last_c(nxt.last), .retry_c(nxt.retry),
    .tabort_c(nxt.tabort), .mabort_c(nxt.mabort), .term_evt(term_evt)
  );

  pci_wait_sort u_wait (
    .dphase(dphase), .irdy(ctl.irdy), .trdy(ctl.trdy), .devsel(ctl.devsel),
    .stop(ctl.stop), .term_seen(term_seen), .mabort_c(nxt.mabort),
    .wait_tgt(nxt.wait_tgt), .wait_mst(nxt.wait_mst), .wait_nodev(nxt.wait_nodev)
  );

  assign nxt.addr = addr_c;
  assign nxt.idle = !ctl.frame && !ctl.irdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      cmd_q   <= '0;
      gnt_q   <= 1'b0;
    end else begin
      flags_q <= nxt;
      gnt_q   <= !gnt_n;
      if (addr_c) cmd_q <= cbe_n;
    end
  end

  assign addr_vld   = flags_q.addr;
  assign data_vld   = flags_q.data;
  assign last_xfer  = flags_q.last;
  assign retry_flag = flags_q.retry;
  assign tgt_abort  = flags_q.tabort;
  assign mst_abort  = flags_q.mabort;
  assign wait_tgt   = flags_q.wait_tgt;
  assign wait_mst   = flags_q.wait_mst;
  assign wait_nodev = flags_q.wait_nodev;
  assign bus_idle   = flags_q.idle;
  assign gnt_held   = gnt_q;
  assign cmd_held   = cmd_q;

  // Checker-only count of clocks since the reported address phase
  logic [CHK_W-1:0] chk_since_addr;
  always_ff @(posedge clk) begin
    if (rst)                          chk_since_addr <= '0;
    else if (addr_vld)                chk_since_addr <= CHK_W'(1);
    else if (chk_since_addr <= CHK_WIN) chk_since_addr <= chk_since_addr + CHK_W'(1);
  end

  assert_addr_no_repeat_R1: assert property (@(posedge clk) disable iff (rst)
    addr_vld |=> !addr_vld);

  assert_retry_once_R4: assert property (@(posedge clk) disable iff (rst)
    retry_flag |=> !retry_flag && !tgt_abort && !mst_abort);

  assert_mabort_after_window_R6: assert property (@(posedge clk) disable iff (rst)
    mst_abort |-> chk_since_addr > CHK_WIN);

  assert_wait_single_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wait_tgt, wait_mst, wait_nodev}) && !((wait_tgt || wait_mst || wait_nodev) && data_vld));

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!addr_vld && !$past(rst)) |-> $stable(cmd_held));

endmodule

// File: tb/pci_phase_tagger_bench.sv
module pci_phase_tagger_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic       stop_n = 1'b1, gnt_n = 1'b1;
  logic [3:0] cbe_n = 4'h0;
  logic       addr_vld, data_vld, last_xfer, retry_flag, tgt_abort, mst_abort;
  logic       wait_tgt, wait_mst, wait_nodev, bus_idle, gnt_held;
  logic [3:0] cmd_held;

  always #10 clk = ~clk;

  pci_phase_tagger u_pci_phase_tagger (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .stop_n(stop_n), .gnt_n(gnt_n), .cbe_n(cbe_n),
    .addr_vld(addr_vld), .data_vld(data_vld), .last_xfer(last_xfer),
    .retry_flag(retry_flag), .tgt_abort(tgt_abort), .mst_abort(mst_abort),
    .wait_tgt(wait_tgt), .wait_mst(wait_mst), .wait_nodev(wait_nodev),
    .bus_idle(bus_idle), .gnt_held(gnt_held), .cmd_held(cmd_held)
  );

  // control selector bits {frame, irdy, trdy, devsel, stop, gnt}, asserted high here
  localparam logic [5:0] F = 6'b100000, I = 6'b010000, T = 6'b001000;
  localparam logic [5:0] D = 6'b000100, S = 6'b000010, G = 6'b000001;
  localparam logic [5:0] N = 6'b000000;
  // expected vector bits
  localparam logic [14:0] E_ADDR = 15'h4000, E_DATA = 15'h2000, E_END  = 15'h1000;
  localparam logic [14:0] E_RTY  = 15'h0800, E_TABT = 15'h0400, E_MABT = 15'h0200;
  localparam logic [14:0] E_WT   = 15'h0100, E_WM   = 15'h0080, E_WN   = 15'h0040;
  localparam logic [14:0] E_IDLE = 15'h0020, E_GNT  = 15'h0010;

  logic [14:0] exp_q[$];
  string       tag_q[$];
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;

  task automatic step(input bit r, input logic [5:0] c, input logic [3:0] cbe,
                      input logic [14:0] e, input string tag);
    @(negedge clk);
    rst      = r;
    frame_n  = !c[5];
    irdy_n   = !c[4];
    trdy_n   = !c[3];
    devsel_n = !c[2];
    stop_n   = !c[1];
    gnt_n    = !c[0];
    cbe_n    = cbe;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [14:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {addr_vld, data_vld, last_xfer, retry_flag, tgt_abort, mst_abort,
           wait_tgt, wait_mst, wait_nodev, bus_idle, gnt_held, cmd_held};
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    step(1, N, 4'h0, 15'h0000, "R11 reset state");
    step(0, N, 4'h0, E_IDLE, "R8 idle");
    // burst read with every wait cause
    step(0, F, 4'h6, E_ADDR | 15'h6, "R1 R9 address and command");
    step(0, F|I, 4'h0, E_WN | 15'h6, "R7 no devsel wait");
    step(0, F|I|D, 4'h0, E_WT | 15'h6, "R7 target wait");
    step(0, F|I|T|D, 4'h0, E_DATA | 15'h6, "R2 transfer");
    step(0, F|T|D, 4'h0, E_WM | 15'h6, "R7 master wait");
    step(0, F|D, 4'h0, E_WM | 15'h6, "R7 neither ready");
    step(0, F|I|T|D, 4'h0, E_DATA | 15'h6, "R1 no re-arm inside transaction");
    step(0, I|T|D, 4'hF, E_DATA | E_END | 15'h6, "R3 final transfer");
    step(0, N, 4'h0, E_IDLE | 15'h6, "R9 command held");
    // retry
    step(0, F|G, 4'h7, E_ADDR | E_GNT | 15'h7, "R10 grant with address");
    step(0, F|I|D|S, 4'h0, E_RTY | 15'h7, "R4 retry");
    step(0, I|D|S, 4'h0, 15'h7, "R4 single pulse");
    step(0, N, 4'h0, E_IDLE | 15'h7, "R8 idle after retry");
    // target abort
    step(0, F, 4'h2, E_ADDR | 15'h2, "R1 address");
    step(0, F|I|D, 4'h0, E_WT | 15'h2, "R7 target wait");
    step(0, F|I|T|D, 4'h0, E_DATA | 15'h2, "R2 transfer");
    step(0, F|I|S, 4'h0, E_TABT | 15'h2, "R5 target abort");
    step(0, I|S, 4'h0, 15'h2, "R5 single pulse");
    step(0, G, 4'h0, E_IDLE | E_GNT | 15'h2, "R10 grant while idle");
    // master abort at the window edge
    step(0, F, 4'h6, E_ADDR | 15'h6, "R1 address");
    for (int k = 0; k < 3; k++) step(0, F|I, 4'h0, E_WN | 15'h6, "R6 inside window");
    step(0, I, 4'h0, E_WN | 15'h6, "R6 release on window clock");
    step(0, I, 4'h0, E_MABT | 15'h6, "R6 master abort");
    step(0, N, 4'h0, E_IDLE | 15'h6, "R8 idle");
    // subtractive decode
    step(0, F, 4'h3, E_ADDR | 15'h3, "R1 address");
    for (int k = 0; k < 3; k++) step(0, F|I, 4'h0, E_WN | 15'h3, "R7 no devsel wait");
    step(0, I|T|D, 4'h0, E_DATA | E_END | 15'h3, "R6 subtractive claim no abort");
    step(0, N, 4'h0, E_IDLE | 15'h3, "R8 idle");
    // reset in mid transaction
    step(0, F, 4'hA, E_ADDR | 15'hA, "R1 address");
    step(1, F|I|T|D, 4'h0, 15'h0000, "R11 reset clears outputs");
    step(0, N, 4'h0, E_IDLE, "R11 command cleared");
    step(0, F, 4'h5, E_ADDR | 15'h5, "R11 fresh address after reset");
    step(0, N, 4'h0, E_IDLE | 15'h5, "R8 idle");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R11: actual %0d pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule